// File: doc/BRIEF.md
# Receive Buffer Ring Descriptor Fetcher

This block walks a circular table of receive-buffer descriptors held in system memory. When the receive path asks for a new buffer, the fetcher reads one descriptor through a simple memory read port. Each descriptor holds four 16-bit fields, in this order: buffer address low, buffer address high, word count low, word count high. The fetcher loads these fields into the current buffer address and buffer word-count registers that the receive path uses.

After the fetch, the table read pointer moves past the descriptor. When it reaches the end of the table it returns to the start of the table. If the read pointer catches up with the software write pointer, the block raises a sticky buffers-exhausted flag and the receiver reports that it cannot take packets. Memory addresses are built from a 16-bit segment register placed above a 16-bit offset. A bus-width mode selects 16-bit or 32-bit slots, so the descriptor stride is 8 or 16 bytes.

Top module: `rra_fetch`

## Requirements
- R1: After reset the block is idle with mem_req, done, irq_update, busy and exhausted low, rd_ptr zero, and buf_addr and buf_words zero.
- R2: Descriptor beat k (k = 0..3) is read at address {seg_hi, rd_ptr + k*S}. S is 2 when wide_mode is 0 and 4 when wide_mode is 1. The offset sum wraps within 16 bits and never carries into the segment. mem_req and mem_addr stay unchanged until a cycle in which mem_valid is high, and that cycle completes the beat.
- R3: Only bits [15:0] of each returned beat are used; bits [31:16] are ignored. buf_addr becomes {beat1, beat0} and buf_words becomes {beat3, beat2}.
- R4: When the fourth beat completes, rd_ptr advances by 8 in 16-bit mode or by 16 in 32-bit mode.
- R5: If the advanced pointer equals ring_end, rd_ptr is loaded with ring_start instead.
- R6: If the final pointer equals wr_ptr, exhausted is set and irq_update pulses for one cycle together with done. exhausted stays high until exh_clr is sampled high. When a set and a clear arrive in the same cycle, the set wins.
- R7: done is high for exactly one cycle, the cycle after the fourth beat completes. In that cycle rd_ptr, buf_addr, buf_words and exhausted already show the new values, and mem_req is low.
- R8: A fetch_req that arrives while a fetch is running is held. It starts a new fetch on the cycle after done. Several such requests during one fetch produce only one extra fetch. busy is high while a fetch runs or a request is held.
- R9: rx_ready is high exactly when rx_en is high and exhausted is low.
- R10: When no fetch is finishing, a cycle with rd_ld high loads rd_wdata into rd_ptr. A finishing fetch takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 32-bit slots, 0 selects 16-bit slots |
| seg_hi | input | 16 | Upper address segment for table reads |
| ring_start | input | 16 | Table start offset |
| ring_end | input | 16 | Table end offset |
| wr_ptr | input | 16 | Software write pointer offset |
| rd_ld | input | 1 | Load rd_ptr from rd_wdata |
| rd_wdata | input | 16 | Value for a read pointer load |
| fetch_req | input | 1 | Request one descriptor fetch |
| exh_clr | input | 1 | Clear the exhausted flag |
| rx_en | input | 1 | Receiver enabled |
| mem_req | output | 1 | Memory read request, held per beat |
| mem_addr | output | 32 | Memory byte address of the current beat |
| mem_valid | input | 1 | Read data valid; completes the beat |
| mem_rdata | input | 32 | Read data |
| buf_addr | output | 32 | Current receive buffer address |
| buf_words | output | 32 | Current receive buffer word count |
| rd_ptr | output | 16 | Table read pointer offset |
| exhausted | output | 1 | Buffers exhausted, sticky |
| irq_update | output | 1 | One-cycle interrupt update request |
| done | output | 1 | One-cycle fetch completion |
| busy | output | 1 | Fetch running or request held |
| rx_ready | output | 1 | Receiver can accept packets |

## Verification
The checker watches some behaviours on every cycle. It checks that a waiting beat holds its request and address, and that done never lasts two cycles and never overlaps a request. It also checks that irq_update comes only with done and a set exhausted flag, that exhausted stays set until a clear, that rx_ready is low whenever exhausted is high, and that a held request always starts a fetch next cycle. Only the bench scenarios can show the other behaviours, using a reference model compared on every clock. These are the beat addresses in both widths, offset wrap inside the segment, the field unpacking with the upper data bits ignored, the table end wrap, exhaustion on meeting the write pointer, a set winning over a clear in the same cycle, and several held requests collapsing into one extra fetch.

// File: rtl/rra_fetch_pkg.sv
package rra_fetch_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } fetch_st_t;
endpackage

// File: rtl/rra_addr_gen.sv
module rra_addr_gen #(
   parameter int SEG_W       = 16,
   parameter int OFS_W       = 16,
   parameter int BEAT_W      = 2,
   parameter int NARROW_STEP = 2,
   parameter int WIDE_OK     = 1
) (
   input  logic                    wide_mode,
   input  logic [SEG_W-1:0]        seg_hi,
   input  logic [OFS_W-1:0]        base_ofs,
   input  logic [BEAT_W-1:0]       beat,
   output logic [SEG_W+OFS_W-1:0]  addr
);
   localparam logic [OFS_W-1:0] N_STEP = OFS_W'(NARROW_STEP);
   localparam logic [OFS_W-1:0] W_STEP = OFS_W'(2 * NARROW_STEP);

   logic [OFS_W-1:0] step;
   logic [OFS_W-1:0] ofs;

   generate
      if (WIDE_OK != 0) begin : g_two_width
         assign step = wide_mode ? W_STEP : N_STEP;
      end else begin : g_one_width
         logic unused_wide;
         assign unused_wide = wide_mode;
         assign step        = N_STEP;
      end
   endgenerate

   // offset arithmetic stays inside the segment
   always_comb begin
      ofs  = base_ofs + (OFS_W'(beat) * step);
      addr = {seg_hi, ofs};
   end
endmodule

// File: rtl/rra_ptr_adv.sv
module rra_ptr_adv #(
   parameter int OFS_W       = 16,
   parameter int NUM_FIELDS  = 4,
   parameter int NARROW_STEP = 2,
   parameter int WIDE_OK     = 1
) (
   input  logic             wide_mode,
   input  logic [OFS_W-1:0] rd_cur,
   input  logic [OFS_W-1:0] ring_start,
   input  logic [OFS_W-1:0] ring_end,
   input  logic [OFS_W-1:0] wr_ptr,
   output logic [OFS_W-1:0] rd_next,
   output logic             meets_wr
);
   localparam logic [OFS_W-1:0] N_SIZE = OFS_W'(NARROW_STEP * NUM_FIELDS);
   localparam logic [OFS_W-1:0] W_SIZE = OFS_W'(2 * NARROW_STEP * NUM_FIELDS);

   logic [OFS_W-1:0] size;
   logic [OFS_W-1:0] bumped;

   generate
      if (WIDE_OK != 0) begin : g_two_width
         assign size = wide_mode ? W_SIZE : N_SIZE;
      end else begin : g_one_width
         logic unused_wide;
         assign unused_wide = wide_mode;
         assign size        = N_SIZE;
      end
   endgenerate

   always_comb begin
      bumped   = rd_cur + size;
      rd_next  = (bumped == ring_end) ? ring_start : bumped;
      meets_wr = (rd_next == wr_ptr);
   end
endmodule

// File: rtl/rra_unpack.sv
module rra_unpack #(
   parameter int FIELD_W    = 16,
   parameter int NUM_FIELDS = 4,
   parameter int BEAT_W     = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          beat_ok,
   input  logic [BEAT_W-1:0]             beat,
   input  logic [FIELD_W-1:0]            word,
   output logic [NUM_FIELDS*FIELD_W-1:0] fields
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
         logic [FIELD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (beat_ok && (beat == BEAT_W'(gi))) begin
               q <= word;
            end
         end
         assign fields[gi*FIELD_W +: FIELD_W] = q;
      end
   endgenerate
endmodule

// File: rtl/rra_fetch.sv
module rra_fetch
   import rra_fetch_pkg::*;
#(
   parameter int SEG_W       = 16,
   parameter int OFS_W       = 16,
   parameter int FIELD_W     = 16,
   parameter int MEM_DW      = 32,
   parameter int NUM_FIELDS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wide_mode,
   input  logic [SEG_W-1:0]        seg_hi,
   input  logic [OFS_W-1:0]        ring_start,
   input  logic [OFS_W-1:0]        ring_end,
   input  logic [OFS_W-1:0]        wr_ptr,
   input  logic                    rd_ld,
   input  logic [OFS_W-1:0]        rd_wdata,
   input  logic                    fetch_req,
   input  logic                    exh_clr,
   input  logic                    rx_en,
   output logic                    mem_req,
   output logic [SEG_W+OFS_W-1:0]  mem_addr,
   input  logic                    mem_valid,
   input  logic [MEM_DW-1:0]       mem_rdata,
   output logic [2*FIELD_W-1:0]    buf_addr,
   output logic [2*FIELD_W-1:0]    buf_words,
   output logic [OFS_W-1:0]        rd_ptr,
   output logic                    exhausted,
   output logic                    irq_update,
   output logic                    done,
   output logic                    busy,
   output logic                    rx_ready
);
   localparam int ADDR_W      = SEG_W + OFS_W;
   localparam int BEAT_W      = $clog2(NUM_FIELDS);
   localparam int NARROW_STEP = FIELD_W / 8;
   localparam int WIDE_OK     = (MEM_DW >= 2 * FIELD_W) ? 1 : 0;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_FIELDS - 1);

   generate
      if (NUM_FIELDS != 4) begin : g_bad_fields
         $error("rra_fetch: descriptor must hold exactly four fields");
      end
      if ((FIELD_W % 8) != 0 || FIELD_W > OFS_W) begin : g_bad_field_w
         $error("rra_fetch: field width must be whole bytes and fit the offset");
      end
      if (MEM_DW < FIELD_W) begin : g_bad_dw
         $error("rra_fetch: memory data narrower than a field");
      end
   endgenerate

   fetch_st_t          st;
   logic [BEAT_W-1:0]  beat;
   logic               held;
   logic [OFS_W-1:0]   rd_q;
   logic               exh_q;
   logic               done_q;
   logic               irq_q;
   logic               beat_ok;
   logic               finish;
   logic [OFS_W-1:0]   rd_next;
   logic               meets_wr;
   logic [NUM_FIELDS*FIELD_W-1:0] fields;

   generate
      if (MEM_DW > FIELD_W) begin : g_hi_bits
         logic unused_hi;
         assign unused_hi = ^mem_rdata[MEM_DW-1:FIELD_W];
      end
   endgenerate

   assign mem_req = (st == ST_FETCH);
   assign beat_ok = mem_req && mem_valid;
   assign finish  = beat_ok && (beat == LAST_BEAT);

   rra_addr_gen #(
      .SEG_W       (SEG_W),
      .OFS_W       (OFS_W),
      .BEAT_W      (BEAT_W),
      .NARROW_STEP (NARROW_STEP),
      .WIDE_OK     (WIDE_OK)
   ) u_addr (
      .wide_mode (wide_mode),
      .seg_hi    (seg_hi),
      .base_ofs  (rd_q),
      .beat      (beat),
      .addr      (mem_addr)
   );

   rra_ptr_adv #(
      .OFS_W       (OFS_W),
      .NUM_FIELDS  (NUM_FIELDS),
      .NARROW_STEP (NARROW_STEP),
      .WIDE_OK     (WIDE_OK)
   ) u_adv (
      .wide_mode  (wide_mode),
      .rd_cur     (rd_q),
      .ring_start (ring_start),
      .ring_end   (ring_end),
      .wr_ptr     (wr_ptr),
      .rd_next    (rd_next),
      .meets_wr   (meets_wr)
   );

   rra_unpack #(
      .FIELD_W    (FIELD_W),
      .NUM_FIELDS (NUM_FIELDS),
      .BEAT_W     (BEAT_W)
   ) u_unpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_ok (beat_ok),
      .beat    (beat),
      .word    (mem_rdata[FIELD_W-1:0]),
      .fields  (fields)
   );

   // sequencing of beats and held requests
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         beat   <= '0;
         held   <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (fetch_req || held) begin
                  st   <= ST_FETCH;
                  beat <= '0;
                  held <= 1'b0;
               end
            end
            ST_FETCH: begin
               if (fetch_req) begin
                  held <= 1'b1;
               end
               if (beat_ok) begin
                  if (beat == LAST_BEAT) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                     irq_q  <= meets_wr;
                  end else begin
                     beat <= beat + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // read pointer and exhaustion flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         exh_q <= 1'b0;
      end else begin
         if (finish) begin
            rd_q <= rd_next;
         end else if (rd_ld) begin
            rd_q <= rd_wdata;
         end
         if (finish && meets_wr) begin
            exh_q <= 1'b1;
         end else if (exh_clr) begin
            exh_q <= 1'b0;
         end
      end
   end

   assign buf_addr   = fields[2*FIELD_W-1:0];
   assign buf_words  = fields[4*FIELD_W-1:2*FIELD_W];
   assign rd_ptr     = rd_q;
   assign exhausted  = exh_q;
   assign irq_update = irq_q;
   assign done       = done_q;
   assign busy       = (st == ST_FETCH) || held;
   assign rx_ready   = rx_en && !exh_q;
endmodule

// File: rtl/rra_fetch_chk.sv
module rra_fetch_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic              irq_update,
   input logic              exhausted,
   input logic              exh_clr,
   input logic              rx_ready,
   input logic              busy
);
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   // R6
   irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_update |-> (done && exhausted));

   // R6
   exh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exhausted && !exh_clr) |=> exhausted);

   // R9
   rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> !rx_ready);

   // R8
   held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req) |=> mem_req);
endmodule

bind rra_fetch rra_fetch_chk #(.ADDR_W(SEG_W + OFS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_valid  (mem_valid),
   .mem_addr   (mem_addr),
   .done       (done),
   .irq_update (irq_update),
   .exhausted  (exhausted),
   .exh_clr    (exh_clr),
   .rx_ready   (rx_ready),
   .busy       (busy)
);

// File: tb/tb_rra_fetch.sv
module tb_rra_fetch;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic [15:0] seg_hi = 16'h0012;
   logic [15:0] ring_start = 16'h0100;
   logic [15:0] ring_end = 16'h0118;
   logic [15:0] wr_ptr = 16'h00F0;
   logic        rd_ld = 1'b0;
   logic [15:0] rd_wdata = 16'h0000;
   logic        fetch_req = 1'b0;
   logic        exh_clr = 1'b0;
   logic        rx_en = 1'b1;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = 32'h0;
   logic [31:0] buf_addr, buf_words;
   logic [15:0] rd_ptr;
   logic        exhausted, irq_update, done, busy, rx_ready;

   int checks = 0;
   int fails  = 0;
   int n_done = 0;
   int n_irq  = 0;
   int wcnt   = 0;

   always #(CLK_P/2) clk = ~clk;

   rra_fetch dut (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .seg_hi(seg_hi),
      .ring_start(ring_start), .ring_end(ring_end), .wr_ptr(wr_ptr),
      .rd_ld(rd_ld), .rd_wdata(rd_wdata), .fetch_req(fetch_req),
      .exh_clr(exh_clr), .rx_en(rx_en), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .buf_addr(buf_addr), .buf_words(buf_words), .rd_ptr(rd_ptr),
      .exhausted(exhausted), .irq_update(irq_update), .done(done),
      .busy(busy), .rx_ready(rx_ready)
   );

   function automatic logic [15:0] lo16(input logic [31:0] a);
      return a[15:0] ^ a[31:16] ^ 16'h3C5A;
   endfunction

   function automatic logic [31:0] beat_addr(input logic [15:0] seg,
      input logic [15:0] base, input int k, input logic w);
      logic [15:0] o;
      o = base + 16'(k * (w ? 4 : 2));
      return {seg, o};
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // memory: variable latency, upper half differs from the used half
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_valid = 1'b0;
         wcnt = 0;
      end else if (mem_valid) begin
         mem_valid = 1'b0;
      end else if (mem_req) begin
         if (wcnt >= (int'(mem_addr[3:1]) % 3)) begin
            mem_valid = 1'b1;
            mem_rdata = {~mem_addr[15:0], lo16(mem_addr)};
            wcnt = 0;
         end else begin
            wcnt++;
         end
      end
      if (rst_n && done) n_done++;
      if (rst_n && irq_update) n_irq++;
   end

   // behavioural reference model, compared every clock
   bit          m_act = 0, m_pend = 0, m_exh = 0, m_done = 0, m_irq = 0;
   int          m_beat = 0;
   logic [15:0] m_rd = 0;
   logic [31:0] m_ba = 0, m_bw = 0;
   bit          m_live = 0;

   always @(posedge clk) begin
      bit acc, fin, hit, was;
      logic [15:0] nx;
      int st;
      if (!rst_n) begin
         m_act = 0; m_pend = 0; m_exh = 0; m_done = 0; m_irq = 0;
         m_beat = 0; m_rd = 0; m_ba = 0; m_bw = 0; m_live = 1;
      end else begin
         st  = wide_mode ? 4 : 2;
         was = m_act;
         acc = m_act && mem_valid;
         fin = 0; hit = 0;
         m_done = 0; m_irq = 0;
         if (acc) begin
            case (m_beat)
               0: m_ba[15:0]  = mem_rdata[15:0];
               1: m_ba[31:16] = mem_rdata[15:0];
               2: m_bw[15:0]  = mem_rdata[15:0];
               default: m_bw[31:16] = mem_rdata[15:0];
            endcase
            if (m_beat == 3) begin
               fin = 1;
               nx = m_rd + 16'(4 * st);
               if (nx == ring_end) nx = ring_start;
               hit = (nx == wr_ptr);
               m_rd = nx; m_act = 0; m_done = 1; m_irq = hit;
            end else begin
               m_beat++;
            end
         end
         if (!fin && rd_ld) m_rd = rd_wdata;
         if (hit) m_exh = 1;
         else if (exh_clr) m_exh = 0;
         if (was && fetch_req) m_pend = 1;
         else if (!was && (fetch_req || m_pend)) begin
            m_act = 1; m_beat = 0; m_pend = 0;
         end
      end
      #(CLK_P/4);
      if (m_live && rst_n) begin
         chk(mem_req == m_act, "R2 mem_req", 32'(mem_req), 32'(m_act));
         if (m_act)
            chk(mem_addr == beat_addr(seg_hi, m_rd, m_beat, wide_mode),
                "R2 mem_addr", mem_addr, beat_addr(seg_hi, m_rd, m_beat, wide_mode));
         chk(buf_addr == m_ba, "R3 buf_addr", buf_addr, m_ba);
         chk(buf_words == m_bw, "R3 buf_words", buf_words, m_bw);
         chk(rd_ptr == m_rd, "R4 rd_ptr", 32'(rd_ptr), 32'(m_rd));
         chk(exhausted == m_exh, "R6 exhausted", 32'(exhausted), 32'(m_exh));
         chk(irq_update == m_irq, "R6 irq_update", 32'(irq_update), 32'(m_irq));
         chk(done == m_done, "R7 done", 32'(done), 32'(m_done));
         chk(busy == (m_act || m_pend), "R8 busy", 32'(busy), 32'(m_act || m_pend));
         chk(rx_ready == (rx_en && !m_exh), "R9 rx_ready", 32'(rx_ready), 32'(rx_en && !m_exh));
      end
   end

   task automatic load_rd(input logic [15:0] v);
      @(negedge clk); rd_ld = 1'b1; rd_wdata = v;
      @(negedge clk); rd_ld = 1'b0;
      chk(rd_ptr == v, "R10 load", 32'(rd_ptr), 32'(v));
   endtask

   task automatic fetch_one();
      int guard = 0;
      @(negedge clk); fetch_req = 1'b1;
      @(negedge clk); fetch_req = 1'b0;
      while (!done && guard < 100) begin
         @(negedge clk); guard++;
      end
      chk(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
      chk(!mem_req, "R7 idle at done", 32'(mem_req), 32'd0);
   endtask

   task automatic chk_bufs(input string tag, input logic [15:0] base);
      logic [31:0] ea, ew;
      ea = {lo16(beat_addr(seg_hi, base, 1, wide_mode)), lo16(beat_addr(seg_hi, base, 0, wide_mode))};
      ew = {lo16(beat_addr(seg_hi, base, 3, wide_mode)), lo16(beat_addr(seg_hi, base, 2, wide_mode))};
      chk(buf_addr == ea, tag, buf_addr, ea);
      chk(buf_words == ew, tag, buf_words, ew);
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int d0, i0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_req && !done && !irq_update && !busy && !exhausted, "R1 controls", 
          {27'd0, mem_req, done, irq_update, busy, exhausted}, 32'd0);
      chk(rd_ptr == 16'h0 && buf_addr == 32'h0 && buf_words == 32'h0, "R1 regs",
          buf_addr | buf_words | 32'(rd_ptr), 32'd0);

      // narrow mode walk with table end wrap
      load_rd(16'h0100);
      fetch_one();
      chk(rd_ptr == 16'h0108, "R4 narrow step", 32'(rd_ptr), 32'h0108);
      chk_bufs("R3 unpack narrow", 16'h0100);
      fetch_one();
      chk(rd_ptr == 16'h0110, "R4 narrow step 2", 32'(rd_ptr), 32'h0110);
      fetch_one();
      chk(rd_ptr == 16'h0100, "R5 wrap to start", 32'(rd_ptr), 32'h0100);
      chk(!exhausted, "R6 no hit", 32'(exhausted), 32'd0);

      // wide mode reaching the write pointer
      wide_mode = 1'b1; ring_end = 16'h0140; wr_ptr = 16'h0120;
      load_rd(16'h0110);
      i0 = n_irq;
      fetch_one();
      chk(rd_ptr == 16'h0120, "R4 wide step", 32'(rd_ptr), 32'h0120);
      chk(exhausted && irq_update, "R6 set with irq", {30'd0, exhausted, irq_update}, 32'd3);
      chk_bufs("R3 unpack wide", 16'h0110);
      chk(!rx_ready, "R9 blocked", 32'(rx_ready), 32'd0);
      repeat (5) @(negedge clk);
      chk(exhausted, "R6 sticky", 32'(exhausted), 32'd1);
      chk(n_irq - i0 == 1, "R6 one irq", 32'(n_irq - i0), 32'd1);
      exh_clr = 1'b1; @(negedge clk); exh_clr = 1'b0;
      chk(!exhausted && rx_ready, "R9 cleared", {30'd0, exhausted, rx_ready}, 32'd1);
      rx_en = 1'b0; @(negedge clk);
      chk(!rx_ready, "R9 rx disabled", 32'(rx_ready), 32'd0);
      rx_en = 1'b1;

      // set wins over a clear in the same cycle
      load_rd(16'h0110);
      exh_clr = 1'b1;
      fetch_one();
      chk(exhausted, "R6 set beats clear", 32'(exhausted), 32'd1);
      @(negedge clk);
      chk(!exhausted, "R6 clear next", 32'(exhausted), 32'd0);
      exh_clr = 1'b0;

      // held requests collapse into one extra fetch
      wr_ptr = 16'h0000;
      load_rd(16'h0100);
      d0 = n_done;
      @(negedge clk); fetch_req = 1'b1;
      @(negedge clk); fetch_req = 1'b0;
      @(negedge clk); fetch_req = 1'b1;
      @(negedge clk); fetch_req = 1'b0;
      @(negedge clk); fetch_req = 1'b1;
      @(negedge clk); fetch_req = 1'b0;
      repeat (60) @(negedge clk);
      chk(n_done - d0 == 2, "R8 two fetches", 32'(n_done - d0), 32'd2);
      chk(rd_ptr == 16'h0120, "R8 pointer", 32'(rd_ptr), 32'h0120);
      chk(!busy, "R8 idle after", 32'(busy), 32'd0);

      // offset wraps within the segment
      wide_mode = 1'b0; ring_start = 16'h0000; ring_end = 16'h0100; wr_ptr = 16'h0200;
      load_rd(16'hFFFC);
      fetch_one();
      chk(rd_ptr == 16'h0004, "R2 offset wrap", 32'(rd_ptr), 32'h0004);
      chk_bufs("R2 segment kept", 16'hFFFC);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule